// File: doc/BRIEF.md
# Console Keyboard and Printer Transfer-Instruction Interface

This block is a paired terminal device for a 12-bit processor that moves characters by programmed I/O. It has a keyboard side and a printer side. Each side has an event flag, an interrupt-enable flip-flop and a character register. The processor issues an I/O transfer instruction with a valid strobe, a 6-bit device code and a 3-bit operation field. In the same cycle, the block returns four things: a skip request, an accumulator-clear request, a value to be ORed into the accumulator, and a reader-advance pulse for a tape reader. It also drives a level interrupt request. Updates to flags and registers take effect at the next clock edge.

On the keyboard side, the operation bits act as micro-operations applied in a fixed order within one cycle: test, then clear, then read. Because the clear comes before the OR, a single combined code loads a character into the accumulator and clears the flag. Characters reach the keyboard through a valid strobe, which the block always accepts. The printer side loads a byte from the accumulator, offers it on a valid/ready output, and sets its flag when the byte is accepted.

Top module: `tty_iot_unit`

## Requirements
- R1: After reset, both flags are clear, both interrupt enables are set, `irq` is low and `txValid` is low.
- R2: A cycle with `rxValid` high captures `rxData` and sets the keyboard flag at the next edge. This holds even when a keyboard clear is issued in the same cycle.
- R3: Operation 1, 3 or 7 (bit 0 set, excluding 5) raises `skip` in the same cycle when that device's flag is set. The test uses the flag value from before any clear in that instruction. A skip-only operation leaves the flag unchanged.
- R4: Operation 2 (bit 1 set, excluding 5) raises `acClear` and clears that device's flag. On the keyboard it also raises `readerAdvance` in the same cycle.
- R5: Keyboard operation 4 (bit 2 set, excluding 5) places the held character on `acOr[7:0]`, with upper bits zero, and leaves the flag unchanged.
- R6: Keyboard operation 6 raises `acClear`, presents the character on `acOr` and pulses `readerAdvance` in one cycle, and clears the keyboard flag.
- R7: Keyboard operation 0 clears the keyboard flag without `readerAdvance` and without `acClear`.
- R8: Keyboard operation 5 loads both interrupt enables from `acIn[0]`, the least significant accumulator bit. It does not skip, clear or read.
- R9: `irq` is high exactly when some flag is set and its own enable is set. Printer operation 5 raises `skip` when `irq` is high.
- R10: Printer operation 4 or 6 loads `acIn[7:0]` and raises `txValid` at the next edge. `txValid` and `txData` then hold until `txReady` is high. The printer flag sets on the edge after the handshake. A load while a byte is pending is ignored. Printer operation 6 also clears the flag and raises `acClear`.
- R11: With `iotValid` low or an unmatched device code, `skip`, `acClear`, `acOr` and `readerAdvance` are zero and no flag or enable changes. Device codes are parameters that default to octal 03 (keyboard) and 04 (printer).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| iotValid | input | 1 | Transfer instruction present this cycle |
| iotDev | input | 6 | Device code of the instruction |
| iotOp | input | 3 | Operation bits of the instruction |
| acIn | input | 12 | Accumulator value from the processor |
| skip | output | 1 | Skip the next instruction |
| acClear | output | 1 | Clear accumulator before OR |
| acOr | output | 12 | Value ORed into accumulator |
| readerAdvance | output | 1 | One-cycle tape reader advance pulse |
| irq | output | 1 | Interrupt request |
| rxValid | input | 1 | Received character strobe |
| rxData | input | 8 | Received character |
| txValid | output | 1 | Printer byte pending |
| txData | output | 8 | Printer byte |
| txReady | input | 1 | Printer sink accepts byte |

## Verification
The bench targets the following corner cases, each paired with the failure it catches:

- A received character landing in the same cycle as a keyboard clear. A design that gives the clear priority drops the character silently.
- A skip combined with a clear. Testing the flag after the clear would never skip.
- A repeated skip-only instruction. If the skip also cleared the flag, the repeat would find the flag clear and fail to skip.
- The enable-load code, seen through `irq` and the printer interrupt-skip. A design that loads only one enable, or uses the wrong accumulator bit, leaves `irq` wrong.
- A second printer load while a byte is pending. A design that lets it through corrupts `txData` before the handshake.

// File: rtl/tty_iot_pkg.sv
package tty_iot_pkg;
  // Strobes from the decode control to the datapath, valid in the IOT cycle.
  typedef struct packed {
    logic kbdClrFlag;  // clear keyboard flag
    logic kbdRead;     // drive keyboard char onto acOr
    logic ieLoad;      // load both interrupt enables from acIn[0]
    logic prtClrFlag;  // clear printer flag
    logic prtLoad;     // capture acIn byte for printing
  } iotStrobes_t;

  localparam logic [2:0] OP_SPECIAL = 3'd5;
endpackage

// File: rtl/tty_iot_ctrl.sv
module tty_iot_ctrl
  import tty_iot_pkg::*;
#(
  parameter int DEV_W = 6,
  parameter logic [DEV_W-1:0] KBD_DEV = 6'o03,
  parameter logic [DEV_W-1:0] PRT_DEV = 6'o04
) (
  input  logic             iotValid,
  input  logic [DEV_W-1:0] iotDev,
  input  logic [2:0]       iotOp,
  input  logic             kbdFlag,
  input  logic             prtFlag,
  input  logic             irq,
  output iotStrobes_t      strobes,
  output logic             skip,
  output logic             acClear,
  output logic             readerAdvance
);
  localparam int N_DEV = 2;
  localparam logic [DEV_W-1:0] DEV_TAB [N_DEV] = '{KBD_DEV, PRT_DEV};

  logic [N_DEV-1:0] devHit;
  logic [N_DEV-1:0] devMicro;
  logic [N_DEV-1:0] devSpecial;

  for (genvar d = 0; d < N_DEV; d++) begin : g_dec
    assign devHit[d]     = iotValid && (iotDev == DEV_TAB[d]);
    assign devSpecial[d] = devHit[d] && (iotOp == OP_SPECIAL);
    assign devMicro[d]   = devHit[d] && (iotOp != OP_SPECIAL);
  end

  always_comb begin
    strobes            = '0;
    strobes.kbdClrFlag = (devHit[0] && (iotOp == 3'd0)) || (devMicro[0] && iotOp[1]);
    strobes.kbdRead    = devMicro[0] && iotOp[2];
    strobes.ieLoad     = devSpecial[0];
    strobes.prtClrFlag = devMicro[1] && iotOp[1];
    strobes.prtLoad    = devMicro[1] && iotOp[2];
  end

  // Skip test uses the flag as it stands before this cycle's clear.
  assign skip = (devMicro[0] && iotOp[0] && kbdFlag) ||
                (devMicro[1] && iotOp[0] && prtFlag) ||
                (devSpecial[1] && irq);
  assign acClear       = (devMicro[0] || devMicro[1]) && iotOp[1];
  assign readerAdvance = devMicro[0] && iotOp[1];
endmodule

// File: rtl/tty_iot_dp.sv
module tty_iot_dp
  import tty_iot_pkg::*;
#(
  parameter int AC_W   = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  iotStrobes_t       strobes,
  input  logic [AC_W-1:0]   acIn,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxData,
  input  logic              txReady,
  output logic              kbdFlag,
  output logic              prtFlag,
  output logic              kbdIe,
  output logic              prtIe,
  output logic [AC_W-1:0]   acOr,
  output logic              irq,
  output logic              txValid,
  output logic [DATA_W-1:0] txData
);
  logic [DATA_W-1:0] kbdChar;
  logic              txAccept;

  assign txAccept = txValid && txReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      kbdFlag <= 1'b0;
      kbdChar <= '0;
    end else begin
      if (rxValid) kbdChar <= rxData;
      if (rxValid)                 kbdFlag <= 1'b1;
      else if (strobes.kbdClrFlag) kbdFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      kbdIe <= 1'b1;
      prtIe <= 1'b1;
    end else if (strobes.ieLoad) begin
      kbdIe <= acIn[0];
      prtIe <= acIn[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prtFlag <= 1'b0;
      txValid <= 1'b0;
      txData  <= '0;
    end else begin
      if (txAccept)                prtFlag <= 1'b1;
      else if (strobes.prtClrFlag) prtFlag <= 1'b0;
      if (strobes.prtLoad && !txValid) begin
        txValid <= 1'b1;
        txData  <= acIn[DATA_W-1:0];
      end else if (txAccept) begin
        txValid <= 1'b0;
      end
    end
  end

  assign acOr = strobes.kbdRead ? AC_W'(kbdChar) : '0;
  assign irq  = (kbdFlag && kbdIe) || (prtFlag && prtIe);
endmodule

// File: rtl/tty_iot_unit.sv
module tty_iot_unit
  import tty_iot_pkg::*;
#(
  parameter int AC_W   = 12,
  parameter int DATA_W = 8,
  parameter int DEV_W  = 6,
  parameter logic [DEV_W-1:0] KBD_DEV = 6'o03,
  parameter logic [DEV_W-1:0] PRT_DEV = 6'o04
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              iotValid,
  input  logic [DEV_W-1:0]  iotDev,
  input  logic [2:0]        iotOp,
  input  logic [AC_W-1:0]   acIn,
  output logic              skip,
  output logic              acClear,
  output logic [AC_W-1:0]   acOr,
  output logic              readerAdvance,
  output logic              irq,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxData,
  output logic              txValid,
  output logic [DATA_W-1:0] txData,
  input  logic              txReady
);
  iotStrobes_t strobes;
  logic kbdFlag, prtFlag, kbdIe, prtIe;

  tty_iot_ctrl #(.DEV_W(DEV_W), .KBD_DEV(KBD_DEV), .PRT_DEV(PRT_DEV)) u_ctrl (
    .iotValid(iotValid), .iotDev(iotDev), .iotOp(iotOp),
    .kbdFlag(kbdFlag), .prtFlag(prtFlag), .irq(irq),
    .strobes(strobes), .skip(skip), .acClear(acClear),
    .readerAdvance(readerAdvance)
  );

  tty_iot_dp #(.AC_W(AC_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .acIn(acIn),
    .rxValid(rxValid), .rxData(rxData), .txReady(txReady),
    .kbdFlag(kbdFlag), .prtFlag(prtFlag), .kbdIe(kbdIe), .prtIe(prtIe),
    .acOr(acOr), .irq(irq), .txValid(txValid), .txData(txData)
  );
endmodule

// File: rtl/tty_iot_chk.sv
module tty_iot_chk #(
  parameter int AC_W   = 12,
  parameter int DATA_W = 8,
  parameter int DEV_W  = 6,
  parameter logic [DEV_W-1:0] KBD_DEV = 6'o03
) (
  input logic              clk,
  input logic              rstN,
  input logic              iotValid,
  input logic [DEV_W-1:0]  iotDev,
  input logic [2:0]        iotOp,
  input logic [AC_W-1:0]   acIn,
  input logic              skip,
  input logic              acClear,
  input logic [AC_W-1:0]   acOr,
  input logic              readerAdvance,
  input logic              rxValid,
  input logic              txValid,
  input logic [DATA_W-1:0] txData,
  input logic              txReady,
  input logic              kbdFlag,
  input logic              prtFlag,
  input logic              kbdIe,
  input logic              prtIe
);
  logic kbdCmd;
  assign kbdCmd = iotValid && (iotDev == KBD_DEV);

  AST_RX_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> kbdFlag); // R2
  AST_SKIP_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (kbdCmd && iotOp == 3'd1 && !rxValid) |=> (kbdFlag == $past(kbdFlag))); // R3
  AST_ADVANCE_WITH_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    readerAdvance |-> acClear); // R4
  AST_CODE0_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (kbdCmd && iotOp == 3'd0 && !rxValid) |=> !kbdFlag); // R7
  AST_IE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (kbdCmd && iotOp == 3'd5) |=> (kbdIe == $past(acIn[0]) && prtIe == $past(acIn[0]))); // R8
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> (txValid && $stable(txData))); // R10
  AST_TX_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |=> prtFlag); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !iotValid |-> (!skip && !acClear && acOr == '0 && !readerAdvance)); // R11
endmodule

bind tty_iot_unit tty_iot_chk #(.AC_W(AC_W), .DATA_W(DATA_W), .DEV_W(DEV_W), .KBD_DEV(KBD_DEV)) u_chk (
  .clk(clk), .rstN(rstN), .iotValid(iotValid), .iotDev(iotDev), .iotOp(iotOp),
  .acIn(acIn), .skip(skip), .acClear(acClear), .acOr(acOr),
  .readerAdvance(readerAdvance), .rxValid(rxValid), .txValid(txValid),
  .txData(txData), .txReady(txReady), .kbdFlag(kbdFlag), .prtFlag(prtFlag),
  .kbdIe(kbdIe), .prtIe(prtIe)
);

// File: tb/tty_iot_unit_tb.sv
module tty_iot_unit_tb;
  localparam logic [5:0] KBD = 6'o03;
  localparam logic [5:0] PRT = 6'o04;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic iotValid = 1'b0;
  logic [5:0] iotDev = '0;
  logic [2:0] iotOp = '0;
  logic [11:0] acIn = '0;
  logic skip, acClear, readerAdvance, irq, txValid;
  logic [11:0] acOr;
  logic rxValid = 1'b0;
  logic [7:0] rxData = '0;
  logic [7:0] txData;
  logic txReady = 1'b0;

  int nChecks = 0;
  int nFails = 0;
  int cycles = 0;
  bit done = 0;

  // Reference state, maintained from the requirements
  bit mKbdFlag, mPrtFlag, mKbdIe, mPrtIe, mTxPend;
  logic [7:0] mKbdChar, mTxData;

  always #10 clk = ~clk;

  tty_iot_unit u_dut (
    .clk(clk), .rstN(rstN), .iotValid(iotValid), .iotDev(iotDev), .iotOp(iotOp),
    .acIn(acIn), .skip(skip), .acClear(acClear), .acOr(acOr),
    .readerAdvance(readerAdvance), .irq(irq), .rxValid(rxValid), .rxData(rxData),
    .txValid(txValid), .txData(txData), .txReady(txReady)
  );

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One cycle: drive at negedge, compare outputs mid-cycle, advance the model at posedge.
  task automatic step(input string tag, input bit v, input logic [5:0] dev,
                      input logic [2:0] op, input logic [11:0] ac,
                      input bit rv, input logic [7:0] rd, input bit tr);
    bit kHit, pHit, kMic, pMic, expIrq, expSkip, expClr, expAdv, accept;
    logic [11:0] expOr;
    @(negedge clk);
    iotValid = v; iotDev = dev; iotOp = op; acIn = ac;
    rxValid = rv; rxData = rd; txReady = tr;
    #5;
    kHit = v && dev == KBD;  pHit = v && dev == PRT;
    kMic = kHit && op != 3'd5; pMic = pHit && op != 3'd5;
    expIrq  = (mKbdFlag && mKbdIe) || (mPrtFlag && mPrtIe);
    expSkip = (kMic && op[0] && mKbdFlag) || (pMic && op[0] && mPrtFlag) ||
              (pHit && op == 3'd5 && expIrq);
    expClr  = (kMic || pMic) && op[1];
    expAdv  = kMic && op[1];
    expOr   = (kMic && op[2]) ? {4'b0, mKbdChar} : 12'h0;
    nChecks++;
    cmp({tag, " R3/R9 skip"}, 32'(skip), 32'(expSkip));
    cmp({tag, " R4 acClear"}, 32'(acClear), 32'(expClr));
    cmp({tag, " R4/R7 readerAdvance"}, 32'(readerAdvance), 32'(expAdv));
    cmp({tag, " R5/R6 acOr"}, 32'(acOr), 32'(expOr));
    cmp({tag, " R9 irq"}, 32'(irq), 32'(expIrq));
    cmp({tag, " R10 txValid"}, 32'(txValid), 32'(mTxPend));
    if (mTxPend) cmp({tag, " R10 txData"}, 32'(txData), 32'(mTxData));
    @(posedge clk);
    accept = mTxPend && tr;
    if (rv) begin mKbdFlag = 1; mKbdChar = rd; end
    else if ((kHit && op == 3'd0) || (kMic && op[1])) mKbdFlag = 0;
    if (kHit && op == 3'd5) begin mKbdIe = ac[0]; mPrtIe = ac[0]; end
    if (accept) mPrtFlag = 1;
    else if (pMic && op[1]) mPrtFlag = 0;
    if (pMic && op[2] && !mTxPend) begin mTxPend = 1; mTxData = ac[7:0]; end
    else if (accept) mTxPend = 0;
  endtask

  task automatic idle(input string tag);
    step(tag, 0, 6'o0, 3'd0, 12'h0, 0, 8'h0, 0);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        nFails++;
        $display("FAIL watchdog expired, actual=%0d expected<100000", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    mKbdFlag = 0; mPrtFlag = 0; mKbdIe = 1; mPrtIe = 1; mTxPend = 0;
    mKbdChar = 0; mTxData = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    idle("R1 reset state");
    step("R1 enable default", 1, PRT, 3'd5, 12'h0, 0, 8'h0, 0);   // no irq yet
    step("R2 receive", 0, 6'o0, 3'd0, 12'h0, 1, 8'h41, 0);
    idle("R1 irq with default enable");                          // irq must be 1
    step("R3 skip", 1, KBD, 3'd1, 12'h0, 0, 8'h0, 0);
    step("R3 skip repeat", 1, KBD, 3'd1, 12'h0, 0, 8'h0, 0);
    step("R5 read", 1, KBD, 3'd4, 12'h0, 0, 8'h0, 0);
    step("R3 skip after read", 1, KBD, 3'd1, 12'h0, 0, 8'h0, 0);
    step("R6 clear and read", 1, KBD, 3'd6, 12'h0, 0, 8'h0, 0);
    step("R6 flag cleared", 1, KBD, 3'd1, 12'h0, 0, 8'h0, 0);
    step("R2 receive", 0, 6'o0, 3'd0, 12'h0, 1, 8'h7e, 0);
    step("R7 code0", 1, KBD, 3'd0, 12'h0, 0, 8'h0, 0);
    step("R7 flag cleared", 1, KBD, 3'd1, 12'h0, 0, 8'h0, 0);
    step("R2 rx wins over clear", 1, KBD, 3'd2, 12'h0, 1, 8'h55, 0);
    step("R2 flag kept", 1, KBD, 3'd7, 12'h0, 0, 8'h0, 0);       // R3 pre-clear skip
    step("R4 clear", 1, KBD, 3'd2, 12'h0, 1, 8'h12, 0);
    step("R8 disable", 1, KBD, 3'd5, 12'hffe, 0, 8'h0, 0);
    step("R9 masked", 1, PRT, 3'd5, 12'h0, 0, 8'h0, 0);
    step("R8 enable", 1, KBD, 3'd5, 12'h001, 0, 8'h0, 0);
    step("R9 printer irq skip", 1, PRT, 3'd5, 12'h0, 0, 8'h0, 0);
    step("R10 load", 1, PRT, 3'd4, 12'hf5a, 0, 8'h0, 0);
    step("R10 pending load ignored", 1, PRT, 3'd6, 12'h033, 0, 8'h0, 0);
    step("R10 hold", 0, 6'o0, 3'd0, 12'h0, 0, 8'h0, 0);
    step("R10 accept", 0, 6'o0, 3'd0, 12'h0, 0, 8'h0, 1);
    step("R10 printer skip", 1, PRT, 3'd1, 12'h0, 0, 8'h0, 0);
    step("R11 other device", 1, 6'o05, 3'd7, 12'hfff, 0, 8'h0, 0);
    step("R11 no strobe", 0, KBD, 3'd6, 12'hfff, 0, 8'h0, 0);
    step("R11 state kept", 1, PRT, 3'd1, 12'h0, 0, 8'h0, 0);
    for (int i = 0; i < 4000; i++) begin
      int sel = $urandom % 4;
      logic [5:0] d = (sel == 0) ? KBD : (sel == 1) ? PRT : 6'($urandom);
      step("R11 random", ($urandom % 3) != 0, d, 3'($urandom), 12'($urandom),
           ($urandom % 5) == 0, 8'($urandom), ($urandom % 2) == 1);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule